// File: doc/BRIEF.md
# Up-Counter with Selectable Clock-Gating Style

This block is an 8-bit up-counter. Its register clock can be derived from the free-running clock in one of several ways, so that the usual ways of gating a clock can be compared side by side in one simulation. A three-bit style code picks the gating scheme:

- a bare AND gate;
- a bare NOR gate;
- an AND gate or a NOR gate, each placed behind a level-sensitive enable latch;
- a recirculating hold multiplexer that leaves the register clock running at all times.

Two further codes request a latched style whose latch is open in the same phase as the counter's active edge. That pairing can let a falling enable sneak in one extra count. The block therefore refuses those codes and raises a flag.

The style code is captured only while reset is held. A bench or a user picks a style, pulses reset, and then drives the enable. The count shows how many active edges the gate let through. A separate output shows the gated clock as the register sees it.

There is no data stream in or out, so there is no valid/ready handshake. All pins are plain control and status signals.

Top module: `gated_style_counter`

## Requirements
- R1: While `rst_n` is low, `count` reads 0 at once without waiting for a clock edge, and the enable latch is held closed at 0. After reset is released during the clock-high phase, `gclk_obs` stays low in a latched style even if `en` is high.
- R2: Style code 0 (bare AND): `count` rises by one at each rising `clk` edge at which `en` is high, when `en` only changes while `clk` is low.
- R3: Style code 0: a short high pulse on `en` while `clk` is high reaches the gated clock and adds exactly one count.
- R4: Style code 1 (bare NOR): `count` rises by one at each rising `clk` edge at which `en` is high, when `en` only changes while `clk` is high.
- R5: Style code 1: a short high pulse on `en` while `clk` is low reaches the gated clock and adds exactly one count.
- R6: Style code 2 (AND behind a latch open while `clk` is low) has the following timing and immunity:
  - An `en` raised just after rising edge k gives the first increment at edge k+1.
  - An `en` dropped just after edge m gives no increment from edge m+1 onward.
  - A pulse on `en` during either clock phase adds nothing.
- R7: Style code 3 (NOR behind a latch open while `clk` is high) has the following behaviour:
  - It counts every rising edge whose preceding high phase ended with `en` high.
  - A pulse on `en` during either clock phase adds nothing.
- R8: Style code 4 (hold multiplexer) has the following behaviour:
  - `gclk_obs` follows `clk`.
  - `count` rises by one at each rising edge with `en` high and holds otherwise.
  - Pulses on `en` between edges add nothing.
- R9: Style codes 5, 6 and 7 are illegal. `style_bad` reads 1 and `count` stays at 0 whatever `en` does. For codes 0 to 4, `style_bad` reads 0.
- R10: `style_sel` is captured at rising `clk` edges while `rst_n` is low. A change of `style_sel` after reset release has no effect on counting or on `style_bad`.
- R11: `count` wraps from 255 to 0.
- R12: In style code 0, `gclk_obs` reads 1 during the clock-high phase when `en` is high. It reads 0 in that phase when `en` is low and in every clock-low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the window in which the style is captured |
| en | input | 1 | Count enable, fed to the selected gating scheme |
| style_sel | input | 3 | Gating style code: 0 AND, 1 NOR, 2 latched AND, 3 latched NOR, 4 hold mux, 5..7 illegal |
| count | output | 8 | Counter value |
| gclk_obs | output | 1 | Gated clock signal, for observation |
| style_bad | output | 1 | High when the captured style code is illegal |

## Verification
The bench builds the block with its default 8-bit count and 3-bit style code. That makes a full sweep over all eight style codes cheap, and a run of a few hundred enabled cycles crosses the wrap point. For every legal style it drives counting runs with the enable timed in the safe clock phase. It also drives enable pulses in each clock phase, which exposes the hazard of the bare gates and the immunity of the latched and multiplexed ones. Expected counts are the number of enabled rising edges plus the per-style hazard increments, taken modulo 256.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  localparam int COUNT_W = 8;
  localparam int STYLE_W = 3;

  // Order of codes matters only in that 5 and above are refused.
  typedef enum logic [STYLE_W-1:0] {
    GS_AND       = 3'd0,
    GS_NOR       = 3'd1,
    GS_LAT_AND   = 3'd2,
    GS_LAT_NOR   = 3'd3,
    GS_HOLD_MUX  = 3'd4,
    GS_AND_SAME  = 3'd5,
    GS_NOR_SAME  = 3'd6,
    GS_RESERVED  = 3'd7
  } gate_style_e;

  localparam gate_style_e FIRST_BAD = GS_AND_SAME;

endpackage

// File: rtl/gsc_en_latch.sv
module gsc_en_latch
  import gsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  gate_style_e style,
  output logic        en_lat
);

  logic open_w;

  // Latch opens in the phase where its gate blocks the clock.
  always_comb begin
    unique case (style)
      GS_LAT_AND:  open_w = ~clk;
      GS_LAT_NOR:  open_w = clk;
      GS_AND_SAME: open_w = clk;
      GS_NOR_SAME: open_w = ~clk;
      default:     open_w = 1'b0;
    endcase
  end

  always_latch begin
    if (!rst_n)      en_lat = 1'b0;
    else if (open_w) en_lat = en;
  end

endmodule

// File: rtl/gsc_clk_gate.sv
module gsc_clk_gate
  import gsc_pkg::*;
(
  input  logic        clk,
  input  logic        en,
  input  logic        en_lat,
  input  gate_style_e style,
  output logic        gclk,
  output logic        cnt_clk
);

  // cnt_clk is always a rising-edge clock for the register.
  // NOR styles fall on the clk rising edge, so they are inverted here.
  always_comb begin
    unique case (style)
      GS_AND: begin
        gclk    = clk & en;
        cnt_clk = gclk;
      end
      GS_NOR: begin
        gclk    = ~(clk | ~en);
        cnt_clk = ~gclk;
      end
      GS_LAT_AND: begin
        gclk    = clk & en_lat;
        cnt_clk = gclk;
      end
      GS_LAT_NOR: begin
        gclk    = ~(clk | ~en_lat);
        cnt_clk = ~gclk;
      end
      GS_HOLD_MUX: begin
        gclk    = clk;
        cnt_clk = clk;
      end
      default: begin
        gclk    = 1'b0;
        cnt_clk = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/gsc_count_reg.sv
module gsc_count_reg #(
  parameter int W = 8
) (
  input  logic         cnt_clk,
  input  logic         rst_n,
  input  logic         step_en,
  output logic [W-1:0] q
);

  // With step_en low the current value recirculates.
  always_ff @(posedge cnt_clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (step_en) q <= q + 1'b1;
  end

endmodule

// File: rtl/gated_style_counter.sv
module gated_style_counter
  import gsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [STYLE_W-1:0] style_sel,
  output logic [COUNT_W-1:0] count,
  output logic               gclk_obs,
  output logic               style_bad
);

  gate_style_e style_q;
  logic        en_lat;
  logic        cnt_clk;
  logic        step_en;

  // Style capture window is the reset period only (R10).
  always_ff @(posedge clk) begin
    if (!rst_n) style_q <= gate_style_e'(style_sel);
  end

  assign style_bad = (style_q >= FIRST_BAD);
  assign step_en   = (style_q == GS_HOLD_MUX) ? en : 1'b1;

  gsc_en_latch u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .style  (style_q),
    .en_lat (en_lat)
  );

  gsc_clk_gate u_gate (
    .clk     (clk),
    .en      (en),
    .en_lat  (en_lat),
    .style   (style_q),
    .gclk    (gclk_obs),
    .cnt_clk (cnt_clk)
  );

  gsc_count_reg #(.W(COUNT_W)) u_cnt (
    .cnt_clk (cnt_clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .q       (count)
  );

  a_r10_style_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(style_q));

  a_r8_mux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (style_q == GS_HOLD_MUX && !en) |=> $stable(count));

  a_r8_mux_step: assert property (@(posedge clk) disable iff (!rst_n)
    (style_q == GS_HOLD_MUX && en) |=> (count == $past(count) + 1'b1));

  a_r9_bad_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    style_bad |=> $stable(count));

  a_r9_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    style_bad |-> (count == '0));

endmodule

// File: tb/gated_style_counter_test.sv
module gated_style_counter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] style_sel = 3'd0;
  logic [7:0] count;
  logic       gclk_obs;
  logic       style_bad;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gated_style_counter uut (
    .clk(clk), .rst_n(rst_n), .en(en), .style_sel(style_sel),
    .count(count), .gclk_obs(gclk_obs), .style_bad(style_bad)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int sel);
    rst_n = 1'b0;
    en = 1'b0;
    style_sel = 3'(sel);
    repeat (2) @(posedge clk);
    #2;
    check(count == 0, "R1 count cleared", count, 0);
    @(negedge clk);
    #2 rst_n = 1'b1;
  endtask

  // Codes 0 and 2 take enable changes in the low phase, the rest in the high phase.
  function automatic bit low_phase(input int s);
    return (s == 0 || s == 2);
  endfunction

  task automatic run_en(input int s, input int n);
    if (low_phase(s)) begin
      @(negedge clk); #2 en = 1'b1;
      repeat (n) @(negedge clk);
      #2 en = 1'b0;
    end else begin
      @(posedge clk); #2 en = 1'b1;
      repeat (n) @(posedge clk);
      #2 en = 1'b0;
    end
    #10;
  endtask

  task automatic pulse_high();
    @(posedge clk); #2 en = 1'b1; #1 en = 1'b0;
    #10;
  endtask

  task automatic pulse_low();
    @(negedge clk); #2 en = 1'b1; #1 en = 1'b0;
    #10;
  endtask

  function automatic string tag_of(input int s);
    case (s)
      0: return "R2";
      1: return "R4";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    int exp;
    // Sweep over the legal styles.
    for (int s = 0; s < 5; s++) begin
      do_reset(s);
      check(style_bad == 0, "R9 legal code not flagged", style_bad, 0);
      exp = 0;
      run_en(s, 3); exp += 3;
      check(count == exp, tag_of(s), count, exp);
      repeat (4) @(posedge clk);
      #2 check(count == exp, tag_of(s), count, exp);
      pulse_high();
      if (s == 0) exp += 1;
      check(count == exp, (s == 0) ? "R3 high-phase pulse" : tag_of(s), count, exp);
      pulse_low();
      if (s == 1) exp += 1;
      check(count == exp, (s == 1) ? "R5 low-phase pulse" : tag_of(s), count, exp);
      run_en(s, 7); exp += 7;
      check(count == exp, tag_of(s), count, exp);
    end

    // R11 wrap in two styles
    for (int k = 0; k < 2; k++) begin
      int s = (k == 0) ? 0 : 4;
      do_reset(s);
      run_en(s, 250);
      check(count == 250, "R11 before wrap", count, 250);
      run_en(s, 10);
      check(count == 4, "R11 wrap", count, 4);
    end

    // R9 illegal codes
    for (int s = 5; s < 8; s++) begin
      do_reset(s);
      check(style_bad == 1, "R9 illegal flagged", style_bad, 1);
      run_en(0, 10);
      run_en(1, 10);
      pulse_high();
      pulse_low();
      check(count == 0, "R9 illegal count frozen", count, 0);
    end

    // R10 select changes after release are ignored
    do_reset(4);
    style_sel = 3'd0;
    run_en(4, 5);
    check(count == 5, "R10 still mux", count, 5);
    pulse_high();
    check(count == 5, "R10 no AND hazard", count, 5);
    style_sel = 3'd6;
    #20 check(style_bad == 0, "R10 flag unchanged", style_bad, 0);
    @(posedge clk); #2;
    check(gclk_obs == 1, "R8 gclk follows clk high", gclk_obs, 1);
    @(negedge clk); #2;
    check(gclk_obs == 0, "R8 gclk follows clk low", gclk_obs, 0);

    // R12 gated clock observation in bare AND
    do_reset(0);
    @(negedge clk); #2 en = 1'b1;
    @(posedge clk); #2;
    check(gclk_obs == 1, "R12 high phase enabled", gclk_obs, 1);
    @(negedge clk); #2;
    check(gclk_obs == 0, "R12 low phase", gclk_obs, 0);
    en = 1'b0;
    @(posedge clk); #2;
    check(gclk_obs == 0, "R12 high phase disabled", gclk_obs, 0);

    // R6 latency of latched AND
    do_reset(2);
    @(posedge clk); #2 en = 1'b1;
    #2 check(count == 0, "R6 no immediate step", count, 0);
    @(posedge clk); #2;
    check(count == 1, "R6 first step next edge", count, 1);
    en = 1'b0;
    @(posedge clk); #2;
    check(count == 1, "R6 stop after drop", count, 1);

    // R1 latch closed after release in the high phase
    rst_n = 1'b0;
    style_sel = 3'd2;
    en = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    #1 check(gclk_obs == 0, "R1 latch closed after release", gclk_obs, 0);
    @(posedge clk); #2;
    check(count == 1, "R6 counts after latch opens", count, 1);
    @(posedge clk); #3 rst_n = 1'b0;
    #1 check(count == 0, "R1 async clear", count, 0);
    en = 1'b0;
    #20 rst_n = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule